// File: doc/BRIEF.md
# Rotating ALU with Skip Decision

This block is the combinational execute stage of a small sequential processor core. It takes two operands and a three-bit function code and forms an arithmetic or bitwise result. That result always goes through a right-rotator set to one of four fixed amounts. The rotator's output is the block's result.

The same stage also decides whether the program counter should step over the next instruction. It looks at the rotated result or at an external input-ready flag. The surrounding core reads the result and the skip flag in the same cycle it presents the operands. The block holds no state, so nothing in it is clocked and it has no reset.

Top module: `alu_rot_skip`

## Requirements
- R1: Function code 0 gives A+B and code 1 gives A-B, both modulo 2^WIDTH, so a carry or borrow out of the top bit is lost.
- R2: Function code 2 gives B+1 and code 3 gives B-1, both modulo 2^WIDTH, so all-ones plus one is zero and zero minus one is all-ones.
- R3: Function codes 4, 5 and 6 give bitwise A AND B, A OR B and A XOR B.
- R4: Function code 7 passes operand A unchanged to the rotator.
- R5: The rotate code picks a right rotation of the function result: 0 means no rotation, 1 means one bit, 2 means eight bits and 3 means sixteen bits. Bits shifted out at the bottom re-enter at the top.
- R6: Skip code 0 holds the skip flag low for every result.
- R7: Skip code 1 raises the skip flag exactly when the rotated result is all zeros.
- R8: Skip code 2 raises the skip flag exactly when bit WIDTH-1 of the rotated result is set.
- R9: Skip code 3 makes the skip flag copy the input-ready flag, whatever the result is. Under the other skip codes the input-ready flag has no effect.
- R10: Both outputs depend only on the present inputs, with no state, and they settle before the next clock edge after any change of input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | WIDTH | First operand. |
| opnd_b | input | WIDTH | Second operand, and the source for increment and decrement. |
| func_sel | input | 3 | Function code. |
| rot_sel | input | 2 | Rotate amount code. |
| skip_sel | input | 2 | Skip condition code. |
| in_ready | input | 1 | External input-available flag. |
| result | output | WIDTH | Rotated function result. |
| skip | output | 1 | Skip decision for the program counter. |

## Verification
The hardest cases to reach from the ports are those where the zero test and the sign test disagree with the unrotated value. One example is a result whose only set bit lands at the top after an 8-bit or 16-bit rotation. Another is a result that is zero only because an addition or a decrement wrapped around. Random operands almost never produce either case. The stimulus therefore runs a directed sweep of every function, rotation and skip code over operands chosen to wrap, to cancel exactly and to carry a lone bit. A seeded random mix of all fields follows the sweep.

// File: rtl/alu_rot_pkg.sv
package alu_rot_pkg;

    typedef enum logic [2:0] {
        FN_ADD  = 3'd0,
        FN_SUB  = 3'd1,
        FN_INC  = 3'd2,
        FN_DEC  = 3'd3,
        FN_AND  = 3'd4,
        FN_OR   = 3'd5,
        FN_XOR  = 3'd6,
        FN_PASS = 3'd7
    } fn_e;

    typedef enum logic [1:0] {
        SK_NEVER = 2'd0,
        SK_ZERO  = 2'd1,
        SK_NEG   = 2'd2,
        SK_READY = 2'd3
    } skip_e;

    localparam int ROT_CHOICES = 4;

    // Rotation distance selected by each rotate code.
    function automatic int rot_distance(input int code);
        case (code)
            0:       return 0;
            1:       return 1;
            2:       return 8;
            default: return 16;
        endcase
    endfunction

endpackage

// File: rtl/alu_func_unit.sv
module alu_func_unit
    import alu_rot_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [2:0]       fn,
    output logic [WIDTH-1:0] y
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    always_comb begin
        unique case (fn_e'(fn))
            FN_ADD:  y = a + b;
            FN_SUB:  y = a - b;
            FN_INC:  y = b + ONE;
            FN_DEC:  y = b - ONE;
            FN_AND:  y = a & b;
            FN_OR:   y = a | b;
            FN_XOR:  y = a ^ b;
            FN_PASS: y = a;
        endcase
    end
endmodule

// File: rtl/alu_rotator.sv
module alu_rotator
    import alu_rot_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] din,
    input  logic [1:0]       sel,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] turned [ROT_CHOICES];

    for (genvar i = 0; i < ROT_CHOICES; i++) begin : g_amt
        localparam int K = rot_distance(i);
        if (K == 0) begin : g_none
            assign turned[i] = din;
        end else begin : g_turn
            assign turned[i] = {din[K-1:0], din[WIDTH-1:K]};
        end
    end

    assign dout = turned[sel];
endmodule

// File: rtl/alu_skip_eval.sv
module alu_skip_eval
    import alu_rot_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] value,
    input  logic [1:0]       cond,
    input  logic             ready,
    output logic             take
);
    localparam int MSB = WIDTH - 1;

    always_comb begin
        unique case (skip_e'(cond))
            SK_NEVER: take = 1'b0;
            SK_ZERO:  take = (value == '0);
            SK_NEG:   take = value[MSB];
            SK_READY: take = ready;
        endcase
    end
endmodule

// File: rtl/alu_rot_skip.sv
module alu_rot_skip #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic [2:0]       func_sel,
    input  logic [1:0]       rot_sel,
    input  logic [1:0]       skip_sel,
    input  logic             in_ready,
    output logic [WIDTH-1:0] result,
    output logic             skip
);
    logic [WIDTH-1:0] raw;

    alu_func_unit #(.WIDTH(WIDTH)) u_func (
        .a(opnd_a), .b(opnd_b), .fn(func_sel), .y(raw)
    );

    alu_rotator #(.WIDTH(WIDTH)) u_rot (
        .din(raw), .sel(rot_sel), .dout(result)
    );

    alu_skip_eval #(.WIDTH(WIDTH)) u_skip (
        .value(result), .cond(skip_sel), .ready(in_ready), .take(skip)
    );
endmodule

// File: rtl/alu_rot_skip_chk.sv
module alu_rot_skip_chk #(
    parameter int WIDTH = 32
) (
    input logic [WIDTH-1:0] opnd_a,
    input logic [2:0]       func_sel,
    input logic [1:0]       rot_sel,
    input logic [1:0]       skip_sel,
    input logic             in_ready,
    input logic [WIDTH-1:0] result,
    input logic             skip
);
    always_comb begin
        // R4
        pass_through_chk: assert (!(func_sel == 3'd7 && rot_sel == 2'd0) || result == opnd_a);
        // R6
        never_skip_chk: assert (skip_sel != 2'd0 || !skip);
        // R7
        zero_skip_chk: assert (skip_sel != 2'd1 || skip == (result == '0));
        // R8
        neg_skip_chk: assert (skip_sel != 2'd2 || skip == result[WIDTH-1]);
        // R9
        ready_skip_chk: assert (skip_sel != 2'd3 || skip == in_ready);
    end
endmodule

bind alu_rot_skip alu_rot_skip_chk #(.WIDTH(WIDTH)) u_chk (
    .opnd_a(opnd_a), .func_sel(func_sel), .rot_sel(rot_sel),
    .skip_sel(skip_sel), .in_ready(in_ready), .result(result), .skip(skip)
);

// File: tb/tb_alu_rot_skip.sv
module tb_alu_rot_skip;
    localparam int W = 32;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic [W-1:0] a, b, res;
    logic [2:0]   fn;
    logic [1:0]   rs, ss;
    logic         rdy, sk;

    int tests = 0, fails = 0;
    bit done = 1'b0;

    alu_rot_skip #(.WIDTH(W)) dut (
        .opnd_a(a), .opnd_b(b), .func_sel(fn), .rot_sel(rs),
        .skip_sel(ss), .in_ready(rdy), .result(res), .skip(sk)
    );

    function automatic logic [W-1:0] ref_fn(logic [W-1:0] x, logic [W-1:0] y, int f);
        case (f)
            0: return x + y;
            1: return x - y;
            2: return y + 1;
            3: return y - 1;
            4: return x & y;
            5: return x | y;
            6: return x ^ y;
            default: return x;
        endcase
    endfunction

    function automatic logic [W-1:0] ref_rot(logic [W-1:0] v, int r);
        int k = (r == 0) ? 0 : (r == 1) ? 1 : (r == 2) ? 8 : 16;
        if (k == 0) return v;
        return (v >> k) | (v << (W - k));
    endfunction

    function automatic logic ref_skip(logic [W-1:0] v, int s, logic rd);
        case (s)
            0: return 1'b0;
            1: return v == '0;
            2: return v[W-1];
            default: return rd;
        endcase
    endfunction

    function automatic string fn_tag(int f, int r);
        string t;
        case (f)
            0, 1: t = "R1";
            2, 3: t = "R2";
            4, 5, 6: t = "R3";
            default: t = "R4";
        endcase
        return (r == 0) ? t : {t, "/R5"};
    endfunction

    function automatic string sk_tag(int s);
        case (s)
            0: return "R6";
            1: return "R7";
            2: return "R8";
            default: return "R9";
        endcase
    endfunction

    // Drive right after a rising edge, sample at the following falling edge (R10).
    task automatic apply(logic [W-1:0] x, logic [W-1:0] y, int f, int r, int s, logic rd);
        logic [W-1:0] er;
        logic es;
        @(posedge clk);
        a = x; b = y; fn = 3'(f); rs = 2'(r); ss = 2'(s); rdy = rd;
        @(negedge clk);
        er = ref_rot(ref_fn(x, y, f), r);
        es = ref_skip(er, s, rd);
        tests++;
        if (res !== er) begin
            fails++;
            $display("FAIL %s result fn=%0d rot=%0d: got %h expected %h", fn_tag(f, r), f, r, res, er);
        end
        tests++;
        if (sk !== es) begin
            fails++;
            $display("FAIL %s skip code=%0d: got %b expected %b", sk_tag(s), s, sk, es);
        end
    endtask

    logic [W-1:0] corner [8];

    initial begin
        int unused;
        unused = $urandom(32'd1234);
        a = '0; b = '0; fn = '0; rs = '0; ss = '0; rdy = 1'b0;
        // Idle inputs: 0+0 gives zero result and no skip (R1, R6)
        @(negedge clk);
        tests++;
        if (res !== '0 || sk !== 1'b0) begin
            fails++;
            $display("FAIL R1 idle: got %h/%b expected 0/0", res, sk);
        end

        corner[0] = '0;           corner[1] = '1;
        corner[2] = 32'h8000_0000; corner[3] = 32'h0000_0001;
        corner[4] = 32'h7FFF_FFFF; corner[5] = 32'h0000_0100;
        corner[6] = 32'h0001_0000; corner[7] = 32'hDEAD_BEEF;

        // Directed sweep: every function, rotation and skip code over corner pairs.
        for (int f = 0; f < 8; f++)
            for (int r = 0; r < 4; r++)
                for (int s = 0; s < 4; s++)
                    for (int i = 0; i < 8; i++) begin
                        apply(corner[i], corner[(i * 3 + 1) % 8], f, r, s, i[0]);
                        apply(corner[i], corner[i], f, r, s, ~i[0]);
                    end

        // R2 wrap and R1 overflow explicitly
        apply('1, '1, 2, 0, 1, 1'b0);          // B+1 wraps to zero -> skip (R2, R7)
        apply('0, '0, 3, 0, 2, 1'b0);          // 0-1 negative -> skip (R2, R8)
        apply(32'h8000_0000, 32'h8000_0000, 0, 0, 1, 1'b0); // R1 overflow to zero
        apply(32'h0000_0080, '0, 7, 2, 2, 1'b0); // R5 lone bit to top after rot8 (R8)
        apply('1, '1, 4, 3, 3, 1'b1);          // R9 ready with non-zero result
        apply('0, '0, 4, 0, 3, 1'b0);          // R9 not ready with zero result

        // Seeded random mix
        for (int n = 0; n < 3000; n++)
            apply($urandom, $urandom, int'($urandom_range(0, 7)), int'($urandom_range(0, 3)),
                  int'($urandom_range(0, 3)), 1'($urandom));

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL R10 watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule